// File: doc/BRIEF.md
# Memory Device Boundary-Scan Test Port

This block is the serial test port of a high-speed memory device. Four serial signals drive it: a test clock, a mode-select line, a serial data input and a serial data output with its own enable. Inside are the sixteen-state test controller and a three-bit instruction register. The instruction picks one of three data paths to sit between serial input and output: a one-bit bypass stage, a 32-bit identification word, or a 109-cell boundary chain. A parallel input vector stands in for the device pads. The boundary chain captures that vector and shifts it out. It also copies its contents to a parallel update vector.

There is no dedicated test-reset pin. An on-chip power-on reset clears the controller. Holding the mode-select line high also brings it back to reset. Board-level pull-ups make undriven select and data lines read as logic 1, so a floating port stays parked in reset. Two instructions request that the memory's read-data drivers go to high impedance: the external-test instruction, and a sampling variant that quiets the outputs while it captures. Plain sampling leaves the outputs alone. Opcodes without an assigned function fall back to the bypass path, so the serial output stays defined whatever is loaded.

Top module: `mem_test_port`

## Requirements
- R1: Power-on reset (por_n low) leaves the controller in Test-Logic-Reset with the instruction IDCODE (001) active, tdo_en low, out_hiz low and pad_out all zero.
- R2: Holding tms high for five rising tck edges returns the controller to Test-Logic-Reset from any state; this reloads IDCODE and drops out_hiz.
- R3: Capture-IR loads 001 into the instruction shift stage. Shifting moves bits toward tdo, least significant bit first. A shifted-in opcode takes effect only at Update-IR.
- R4: Under IDCODE, Capture-DR loads a 32-bit word that shifts out LSB first. Bit 0 is 1 and bits 11:1 hold the vendor code (default 0x2A5). Bits 22:12 hold the density code (default 0x015) and bits 24:23 the width code (11 for x36, 10 for x18, 00 for x9; default 11). Bit 25 is the separate-I/O flag (default 1), bit 26 the four-beat-burst flag (default 0), bit 27 the quad-rate flag (default 1) and bit 28 the DLL flag (default 1). Bits 31:29 hold the revision (default 0).
- R5: BYPASS (111) and the unassigned opcodes 011, 101 and 110 select a one-bit stage that Capture-DR clears to 0. Data from tdi therefore appears on tdo one shift later, after a leading 0.
- R6: SAMPLE (100) makes Capture-DR load pad_in into the 109-cell chain, which shifts out with pad_in[0] first. out_hiz stays low.
- R7: out_hiz is high exactly while EXTEST (000) or SAMPLE-Z (010) is the active instruction. It changes only at Update-IR or Test-Logic-Reset.
- R8: Update-DR under EXTEST, SAMPLE or SAMPLE-Z copies the chain to pad_out. Under any other instruction, and in every other state, pad_out holds its value.
- R9: tdo and tdo_en change only on falling tck edges. tdo_en is high only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| por_n | input | 1 | On-chip power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| pad_in | input | 109 | Parallel pad values captured by the boundary chain |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_en | output | 1 | Output enable for tdo |
| out_hiz | output | 1 | Request to float the memory read-data drivers |
| pad_out | output | 109 | Boundary update stage contents |

## Verification
The hardest case to reach is the mode-select reset taken from deep inside the data column while a high-impedance instruction is active. The stimulus loads EXTEST, walks from Capture-DR straight to Exit1-DR and into Pause-DR without shifting, and then holds tms high. The bench then checks that out_hiz has dropped and that a fresh scan returns the identification word. The unassigned opcodes are each loaded in turn and scanned, to confirm that the bypass timing matches BYPASS.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SHIFT_DR, ST_EXIT1_DR, ST_PAUSE_DR, ST_EXIT2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHIFT_IR, ST_EXIT1_IR, ST_PAUSE_IR, ST_EXIT2_IR, ST_UPD_IR
    } tap_state_e;

    localparam int OP_W = 3;
    localparam logic [OP_W-1:0] OP_EXTEST  = 3'b000;
    localparam logic [OP_W-1:0] OP_IDCODE  = 3'b001;
    localparam logic [OP_W-1:0] OP_SAMPLEZ = 3'b010;
    localparam logic [OP_W-1:0] OP_SAMPLE  = 3'b100;
    localparam logic [OP_W-1:0] OP_BYPASS  = 3'b111;
    localparam int ID_W = 32;
endpackage

// File: rtl/mtp_ctrl_fsm.sv
module mtp_ctrl_fsm
    import mtp_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state
);
    typedef struct packed {
        tap_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_RESET:    fsm_d.st = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     fsm_d.st = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   fsm_d.st = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   fsm_d.st = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: fsm_d.st = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: fsm_d.st = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: fsm_d.st = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: fsm_d.st = tms ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   fsm_d.st = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   fsm_d.st = tms ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   fsm_d.st = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: fsm_d.st = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: fsm_d.st = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: fsm_d.st = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: fsm_d.st = tms ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   fsm_d.st = tms ? ST_SEL_DR   : ST_IDLE;
            default:     fsm_d.st = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) fsm_q <= '{st: ST_RESET};
        else        fsm_q <= fsm_d;
    end

    assign state = fsm_q.st;

    // R2: once in reset, a high tms keeps it there
    a_r2_reset_hold: assert property (@(posedge tck) disable iff (!por_n)
        (fsm_q.st == ST_RESET && tms) |=> (fsm_q.st == ST_RESET));
endmodule

// File: rtl/mtp_instr_reg.sv
module mtp_instr_reg
    import mtp_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tdi,
    input  tap_state_e state,
    output logic       ir_lsb,
    output logic       sel_chain,
    output logic       sel_ident,
    output logic       hiz_req
);
    typedef struct packed {
        logic [OP_W-1:0] sh;
        logic [OP_W-1:0] cur;
    } ir_t;

    ir_t ir_d, ir_q;

    always_comb begin
        ir_d = ir_q;
        unique case (state)
            ST_RESET:    ir_d.cur = OP_IDCODE;
            ST_CAP_IR:   ir_d.sh  = {{(OP_W-1){1'b0}}, 1'b1};
            ST_SHIFT_IR: ir_d.sh  = {tdi, ir_q.sh[OP_W-1:1]};
            ST_UPD_IR:   ir_d.cur = ir_q.sh;
            default:     ;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) ir_q <= '{sh: '0, cur: OP_IDCODE};
        else        ir_q <= ir_d;
    end

    assign ir_lsb    = ir_q.sh[0];
    assign sel_chain = (ir_q.cur == OP_EXTEST) || (ir_q.cur == OP_SAMPLE) ||
                       (ir_q.cur == OP_SAMPLEZ);
    assign sel_ident = (ir_q.cur == OP_IDCODE);
    assign hiz_req   = (ir_q.cur == OP_EXTEST) || (ir_q.cur == OP_SAMPLEZ);

    // R1: reset state always leaves IDCODE active
    a_r1_idcode_on_reset: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_RESET) |=> (ir_q.cur == OP_IDCODE));
endmodule

// File: rtl/mtp_data_regs.sv
module mtp_data_regs
    import mtp_pkg::*;
#(
    parameter int          CHAIN_LEN  = 109,
    parameter logic [2:0]  ID_REV     = 3'd0,
    parameter logic        CFG_DLL    = 1'b1,
    parameter logic        CFG_QUAD   = 1'b1,
    parameter logic        CFG_BURST4 = 1'b0,
    parameter logic        CFG_SEPIO  = 1'b1,
    parameter logic [1:0]  CFG_WIDTH  = 2'b11,
    parameter logic [10:0] ID_DENS    = 11'h015,
    parameter logic [10:0] ID_VENDOR  = 11'h2A5
) (
    input  logic                 tck,
    input  logic                 por_n,
    input  logic                 tdi,
    input  tap_state_e           state,
    input  logic                 sel_chain,
    input  logic                 sel_ident,
    input  logic [CHAIN_LEN-1:0] pad_in,
    output logic                 dr_lsb,
    output logic [CHAIN_LEN-1:0] pad_out
);
    localparam logic [ID_W-1:0] ID_WORD = {ID_REV, CFG_DLL, CFG_QUAD, CFG_BURST4,
                                           CFG_SEPIO, CFG_WIDTH, ID_DENS, ID_VENDOR, 1'b1};

    typedef struct packed {
        logic [CHAIN_LEN-1:0] chain;
        logic [CHAIN_LEN-1:0] upd;
        logic [ID_W-1:0]      ident;
        logic                 byp;
    } dr_t;

    dr_t dr_d, dr_q;
    logic [CHAIN_LEN-1:0] cell_nxt;
    logic cap_en, shf_en;

    assign cap_en = (state == ST_CAP_DR) && sel_chain;
    assign shf_en = (state == ST_SHIFT_DR) && sel_chain;

    for (genvar g = 0; g < CHAIN_LEN; g++) begin : g_cell
        logic feed;
        if (g == CHAIN_LEN - 1) begin : g_head
            assign feed = tdi;
        end else begin : g_body
            assign feed = dr_q.chain[g+1];
        end
        assign cell_nxt[g] = cap_en ? pad_in[g] : (shf_en ? feed : dr_q.chain[g]);
    end

    always_comb begin
        dr_d = dr_q;
        dr_d.chain = cell_nxt;
        unique case (state)
            ST_CAP_DR: begin
                if (sel_ident)       dr_d.ident = ID_WORD;
                else if (!sel_chain) dr_d.byp   = 1'b0;
            end
            ST_SHIFT_DR: begin
                if (sel_ident)       dr_d.ident = {tdi, dr_q.ident[ID_W-1:1]};
                else if (!sel_chain) dr_d.byp   = tdi;
            end
            ST_UPD_DR: if (sel_chain) dr_d.upd = dr_q.chain;
            default: ;
        endcase
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) dr_q <= '{chain: '0, upd: '0, ident: ID_WORD, byp: 1'b0};
        else        dr_q <= dr_d;
    end

    assign dr_lsb  = sel_chain ? dr_q.chain[0] : (sel_ident ? dr_q.ident[0] : dr_q.byp);
    assign pad_out = dr_q.upd;

    // R8: update stage moves only on Update-DR of a chain instruction
    a_r8_update_hold: assert property (@(posedge tck) disable iff (!por_n)
        !(state == ST_UPD_DR && sel_chain) |=> $stable(pad_out));
    // R5: bypass stage captures 0
    a_r5_bypass_zero: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_CAP_DR && !sel_chain && !sel_ident) |=> (dr_q.byp == 1'b0));
endmodule

// File: rtl/mem_test_port.sv
module mem_test_port
    import mtp_pkg::*;
#(
    parameter int CHAIN_LEN = 109
) (
    input  logic                 tck,
    input  logic                 por_n,
    input  logic                 tms,
    input  logic                 tdi,
    input  logic [CHAIN_LEN-1:0] pad_in,
    output logic                 tdo,
    output logic                 tdo_en,
    output logic                 out_hiz,
    output logic [CHAIN_LEN-1:0] pad_out
);
    tap_state_e state;
    logic ir_lsb, dr_lsb, sel_chain, sel_ident;

    mtp_ctrl_fsm u_fsm (.tck(tck), .por_n(por_n), .tms(tms), .state(state));

    mtp_instr_reg u_ir (
        .tck(tck), .por_n(por_n), .tdi(tdi), .state(state), .ir_lsb(ir_lsb),
        .sel_chain(sel_chain), .sel_ident(sel_ident), .hiz_req(out_hiz)
    );

    mtp_data_regs #(.CHAIN_LEN(CHAIN_LEN)) u_dr (
        .tck(tck), .por_n(por_n), .tdi(tdi), .state(state), .sel_chain(sel_chain),
        .sel_ident(sel_ident), .pad_in(pad_in), .dr_lsb(dr_lsb), .pad_out(pad_out)
    );

    typedef struct packed {
        logic bit_out;
        logic en;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        out_d.en = (state == ST_SHIFT_IR) || (state == ST_SHIFT_DR);
        if (state == ST_SHIFT_IR)      out_d.bit_out = ir_lsb;
        else if (state == ST_SHIFT_DR) out_d.bit_out = dr_lsb;
    end

    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) out_q <= '{bit_out: 1'b0, en: 1'b0};
        else        out_q <= out_d;
    end

    assign tdo    = out_q.bit_out;
    assign tdo_en = out_q.en;

    // R7: the high-impedance request moves only at Update-IR or reset
    a_r7_hiz_hold: assert property (@(posedge tck) disable iff (!por_n)
        (state != ST_UPD_IR && state != ST_RESET) |=> $stable(out_hiz));
    // R9: at each rising edge the enable matches the shift states
    a_r9_enable_shift: assert property (@(posedge tck) disable iff (!por_n)
        tdo_en == (state == ST_SHIFT_IR || state == ST_SHIFT_DR));
endmodule

// File: tb/mem_test_port_tb_top.sv
module mem_test_port_tb_top;
    localparam int LEN = 109;

    logic tck = 1'b0;
    logic por_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b1;
    logic [LEN-1:0] pad_in = '0;
    logic tdo, tdo_en, out_hiz;
    logic [LEN-1:0] pad_out;

    always #2.5 tck = ~tck;

    mem_test_port dut_i (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pad_in(pad_in),
        .tdo(tdo), .tdo_en(tdo_en), .out_hiz(out_hiz), .pad_out(pad_out)
    );

    typedef struct {
        logic  v;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // monitor: pop one expected bit per rising edge while tdo is enabled
    always @(posedge tck) begin
        if (por_n && tdo_en) begin
            logic v;
            v = tdo;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected shift", {127'd0, v}, 128'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(v === e.v, e.req, {127'd0, v}, {127'd0, e.v});
            end
            #1;
            chk(tdo === v, "R9 tdo moved at rising edge", {127'd0, tdo}, {127'd0, v});
        end
    end

    task automatic step(input logic m, input logic d);
        @(negedge tck);
        #0.5;
        tms = m;
        tdi = d;
    endtask

    task automatic settle();
        @(negedge tck);
        #1;
    endtask

    // from Run-Test/Idle, load an opcode and return to Run-Test/Idle
    task automatic load_ir(input logic [2:0] op);
        for (int i = 0; i < 3; i++) exp_q.push_back('{v: (i == 0), req: "R3"});
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 3; i++) step(i == 2, op[i]);
        step(1, 0); step(0, 0);
        settle();
    endtask

    // from Run-Test/Idle, scan n bits through the selected data path
    task automatic scan_dr(input int n, input logic [127:0] din,
                           input logic [127:0] expv, input string req);
        for (int i = 0; i < n; i++) exp_q.push_back('{v: expv[i], req: req});
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) step(i == n - 1, din[i]);
        step(1, 0); step(0, 0);
        settle();
    endtask

    task automatic scan_chain(input logic [LEN-1:0] din, input logic [LEN-1:0] expv,
                              input string req);
        for (int i = 0; i < LEN; i++) exp_q.push_back('{v: expv[i], req: req});
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < LEN; i++) step(i == LEN - 1, din[i]);
        step(1, 0); step(0, 0);
        settle();
    endtask

    task automatic reset_by_tms();
        for (int i = 0; i < 5; i++) step(1, 1);
        step(0, 1);
        settle();
    endtask

    task automatic run_tests();
        logic [31:0]    id_word;
        logic [LEN-1:0] pat, din;
        logic [2:0]     byp_ops [4];
        logic [7:0]     bdin;
        logic [127:0]   bexp;

        id_word = {3'b000, 1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 11'h015, 11'h2A5, 1'b1};
        byp_ops = '{3'b111, 3'b011, 3'b101, 3'b110};

        repeat (3) @(negedge tck);
        por_n = 1'b1;
        settle();
        // R1: power-on state
        chk(tdo_en == 1'b0, "R1 tdo_en", {127'd0, tdo_en}, 128'd0);
        chk(out_hiz == 1'b0, "R1 out_hiz", {127'd0, out_hiz}, 128'd0);
        chk(pad_out == '0, "R1 pad_out", {19'd0, pad_out}, 128'd0);
        step(0, 1);
        settle();
        // R1 / R4: IDCODE active after power-on, fields packed as required
        scan_dr(32, 128'h0, {96'd0, id_word}, "R4");
        chk(tdo_en == 1'b0, "R9 enable low in idle", {127'd0, tdo_en}, 128'd0);

        // R5: bypass and unassigned opcodes
        bdin = 8'hA5;
        bexp = '0;
        for (int i = 1; i < 8; i++) bexp[i] = bdin[i-1];
        foreach (byp_ops[k]) begin
            load_ir(byp_ops[k]);
            chk(out_hiz == 1'b0, "R7 no hiz for bypass", {127'd0, out_hiz}, 128'd0);
            scan_dr(8, {120'd0, bdin}, bexp, "R5");
        end

        // R6: SAMPLE captures pads, R8 update copies chain
        for (int i = 0; i < LEN; i++) pat[i] = ((i * 7 + 3) % 5) < 2;
        for (int i = 0; i < LEN; i++) din[i] = (i % 3) == 0;
        pad_in = pat;
        load_ir(3'b100);
        chk(out_hiz == 1'b0, "R6 SAMPLE keeps outputs driven", {127'd0, out_hiz}, 128'd0);
        scan_chain(din, pat, "R6");
        chk(pad_out == din, "R8 update under SAMPLE", {19'd0, pad_out}, {19'd0, din});

        // R8: a scan under IDCODE leaves pad_out alone; R3 old opcode active until update
        load_ir(3'b001);
        scan_dr(32, 128'h0, {96'd0, id_word}, "R3 IDCODE reload");
        chk(pad_out == din, "R8 hold under IDCODE", {19'd0, pad_out}, {19'd0, din});

        // R7: SAMPLE-Z requests high impedance and still captures pads
        pad_in = ~pat;
        load_ir(3'b010);
        chk(out_hiz == 1'b1, "R7 SAMPLE-Z hiz", {127'd0, out_hiz}, 128'd1);
        scan_chain(pat, ~pat, "R7 SAMPLE-Z capture");
        chk(pad_out == pat, "R8 update under SAMPLE-Z", {19'd0, pad_out}, {19'd0, pat});

        // R7: EXTEST requests high impedance
        load_ir(3'b000);
        chk(out_hiz == 1'b1, "R7 EXTEST hiz", {127'd0, out_hiz}, 128'd1);

        // R2: reset by tms from Pause-DR, no shifting on the way
        step(1, 0); step(0, 0); step(1, 0); step(0, 0);
        settle();
        chk(out_hiz == 1'b1, "R7 hiz held in Pause-DR", {127'd0, out_hiz}, 128'd1);
        chk(pad_out == pat, "R8 hold without update", {19'd0, pad_out}, {19'd0, pat});
        reset_by_tms();
        chk(out_hiz == 1'b0, "R2 hiz dropped", {127'd0, out_hiz}, 128'd0);
        scan_dr(32, 128'h0, {96'd0, id_word}, "R2 IDCODE after tms reset");
        chk(exp_q.size() == 0, "R9 all expected bits shifted", exp_q.size(), 128'd0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                #500000;
                chk(1'b0, "watchdog expired", 128'd0, 128'd1);
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule